// File: doc/BRIEF.md
# Shared-Vector Port Interrupt Edge Latch

This block holds the interrupt logic for a group of port pins that share one interrupt vector. Each pin has three mode bits (direction, option, data) that decide whether it takes part in the shared interrupt, sits as a plain input, or is an output. The pins are folded into one internal level, and a single edge detector watches that level. Its polarity follows a global edge-select input. A detected edge sets a pending latch. The latch drives the request output until an acknowledge strobe clears it.

The block keeps the behaviour of the real shared-vector circuit on purpose. One enabled pin parked at its active level hides edges on every other pin in the group. Writes to the mode bits or to the edge-select bit can move the merged level and so latch a request when no pin moved. Software that uses the block must expect these requests and filter them.

The pending latch is a two-state machine with states `ST_IDLE` and `ST_PEND`. The transitions are:
- T_SET: `ST_IDLE` to `ST_PEND` on a detected edge.
- T_CLEAR: `ST_PEND` to `ST_IDLE` on an acknowledge with no edge in the same cycle.
- T_KEEP: `ST_PEND` to `ST_PEND` when there is no acknowledge, or when an edge and an acknowledge arrive together.

Top module: `pint_shared_vec`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq` is 0. With no detected edge, `irq` never rises.
- R2: Pin modes are decoded from {dir,opt,dat}:
  - dir=1 is an output. It never affects the merged level, whatever its pin does.
  - dir=0, opt=1, dat=0 is an interrupt input with pull-up.
  - dir=0 with opt=0 is a plain input, and dir=0, opt=1, dat=1 is also a plain input.
- R3: With `edge_rise`=0, a 1-to-0 change on an interrupt pin sets `irq` at the next rising clock edge, provided every other interrupt pin is at 1. A 0-to-1 change sets nothing.
- R4: With `edge_rise`=1, a 0-to-1 change on an interrupt pin sets `irq` at the next rising clock edge, provided every other interrupt pin is at 0 and every plain input is at 1. A 1-to-0 change sets nothing.
- R5: With `edge_rise`=0, while any interrupt pin is held at 0, a falling change on another interrupt pin does not set `irq`.
- R6: With `edge_rise`=1, while any interrupt pin is held at 1, a rising change on another interrupt pin does not set `irq`.
- R7: Once the masking pin returns to its idle level or leaves interrupt mode, an active change on another interrupt pin sets `irq` again.
- R8: With `edge_rise`=0, switching a pin that reads 0 from plain input to interrupt input sets `irq` without any pin edge.
- R9: With `edge_rise`=1, switching a pin that reads 0 from interrupt input to plain input sets `irq` without any pin edge.
- R10: Changing `edge_rise` from 0 to 1 while all interrupt pins sit at 1 sets `irq` without any pin edge.
- R11: A one-cycle `irq_ack` clears `irq` at the next clock edge. If an edge is detected in the same cycle, `irq` stays 1. With no acknowledge, `irq` holds.
- R12: Plain inputs have no effect in falling mode. In rising mode a plain input contributes its own level, so a plain input at 0 masks the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Pin levels, already synchronised |
| pin_dir | input | NPINS | Direction bit per pin, 1 = output |
| pin_opt | input | NPINS | Option bit per pin |
| pin_dat | input | NPINS | Data bit per pin |
| edge_rise | input | 1 | Edge select, 0 = falling, 1 = rising |
| irq_ack | input | 1 | One-cycle acknowledge strobe |
| irq | output | 1 | Pending interrupt request |

## Verification
The main function is tried with every ordered pair of 4-bit pin patterns in both polarities, with all pins in interrupt mode. This separates a real single-pin edge from a change that masked pins hide, and from a change whose direction does not match the polarity.

Directed sequences then walk through several cases:
- each masking case, followed by release of the masking pin or removal of its mode;
- each configuration-write case, which must latch with no pin movement;
- output and plain pins, which are shown to leave the level untouched where R2 and R12 say they must;
- the acknowledge-versus-edge collision, which shows whether a simultaneous edge wins.

// File: rtl/pint_pkg.sv
package pint_pkg;

    typedef enum logic [1:0] {
        PM_OUTPUT = 2'd0,
        PM_PLAIN  = 2'd1,
        PM_INT_PU = 2'd2,
        PM_FLOAT  = 2'd3
    } pin_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } pend_state_e;

    function automatic pin_mode_e decode_mode(input logic dir, input logic opt, input logic dat);
        pin_mode_e m;
        if (dir)
            m = PM_OUTPUT;
        else if (!opt)
            m = PM_PLAIN;
        else if (!dat)
            m = PM_INT_PU;
        else
            m = PM_FLOAT;
        return m;
    endfunction

endpackage

// File: rtl/pint_term.sv
module pint_term
    import pint_pkg::*;
(
    input  logic dir,
    input  logic opt,
    input  logic dat,
    input  logic pin,
    input  logic edge_rise,
    output logic term
);

    pin_mode_e mode;

    always_comb begin
        mode = decode_mode(dir, opt, dat);
        unique case (mode)
            PM_OUTPUT: term = 1'b1;                 // outputs are neutral
            PM_INT_PU: term = pin ^ edge_rise;      // active level is 0 after polarity
            PM_PLAIN,
            PM_FLOAT:  term = pin | ~edge_rise;     // neutral when falling, own level when rising
            default:   term = 1'b1;
        endcase
    end

endmodule

// File: rtl/pint_edge.sv
module pint_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic edge_hit
);

    logic prev_q;

    // prev resets low so no edge can appear in the first cycle after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= level;
    end

    always_comb edge_hit = prev_q & ~level;

endmodule

// File: rtl/pint_pend_fsm.sv
module pint_pend_fsm
    import pint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_hit,
    input  logic ack,
    output logic irq
);

    pend_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (edge_hit) state_d = ST_PEND;          // T_SET
            ST_PEND: if (ack && !edge_hit) state_d = ST_IDLE;  // T_CLEAR, else T_KEEP
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb irq = (state_q == ST_PEND);

endmodule

// File: rtl/pint_shared_vec.sv
module pint_shared_vec #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pin_dir,
    input  logic [NPINS-1:0] pin_opt,
    input  logic [NPINS-1:0] pin_dat,
    input  logic             edge_rise,
    input  logic             irq_ack,
    output logic             irq
);

    localparam int LAST = NPINS - 1;

    logic [LAST:0] terms;
    logic          merged;
    logic          edge_hit;

    for (genvar i = 0; i < NPINS; i++) begin : g_term
        pint_term u_term (
            .dir       (pin_dir[i]),
            .opt       (pin_opt[i]),
            .dat       (pin_dat[i]),
            .pin       (pin_in[i]),
            .edge_rise (edge_rise),
            .term      (terms[i])
        );
    end

    always_comb merged = &terms;

    pint_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (merged),
        .edge_hit (edge_hit)
    );

    pint_pend_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .ack      (irq_ack),
        .irq      (irq)
    );

endmodule

// File: rtl/pint_shared_vec_chk.sv
module pint_shared_vec_chk #(
    parameter int NPINS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] pin_dir,
    input logic [NPINS-1:0] pin_opt,
    input logic [NPINS-1:0] pin_dat,
    input logic             edge_rise,
    input logic             irq_ack,
    input logic             irq,
    input logic             edge_hit,
    input logic             merged
);

    logic [NPINS-1:0] int_en;
    always_comb int_en = ~pin_dir & pin_opt & ~pin_dat;

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !irq);

    p_no_spont_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !edge_hit) |=> !irq);

    p_set_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> irq);

    p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack && !edge_hit) |=> !irq);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    p_mask_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_rise && |(int_en & ~pin_in)) |-> !merged);

    p_mask_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_rise && |(int_en & pin_in)) |-> !merged);

endmodule

bind pint_shared_vec pint_shared_vec_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .pin_dir   (pin_dir),
    .pin_opt   (pin_opt),
    .pin_dat   (pin_dat),
    .edge_rise (edge_rise),
    .irq_ack   (irq_ack),
    .irq       (irq),
    .edge_hit  (edge_hit),
    .merged    (merged)
);

// File: tb/pint_shared_vec_tb.sv
module pint_shared_vec_tb;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = '1;
    logic [N-1:0] pin_dir = '0;
    logic [N-1:0] pin_opt = '0;
    logic [N-1:0] pin_dat = '0;
    logic         edge_rise = 1'b0;
    logic         irq_ack = 1'b0;
    logic         irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pint_shared_vec #(.NPINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
        .pin_opt(pin_opt), .pin_dat(pin_dat), .edge_rise(edge_rise),
        .irq_ack(irq_ack), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk);
        pin_in[i] = v;
        tick();
    endtask

    task automatic set_opt(input int i, input logic v);
        @(negedge clk);
        pin_opt[i] = v;
        tick();
    endtask

    task automatic do_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        tick();
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    function automatic logic ref_lvl(input logic [N-1:0] p, input logic e);
        return &(p ^ {N{e}});
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: irq=%0b expected completion", irq);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R1 in reset", irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 first cycle", irq, 1'b0);
        repeat (3) tick();
        chk("R1 idle", irq, 1'b0);

        // R2: an output pin is ignored
        @(negedge clk);
        pin_dir[0] = 1'b1;
        pin_opt[0] = 1'b1;
        tick();
        set_pin(0, 1'b0);
        chk("R2 output toggle", irq, 1'b0);
        set_pin(0, 1'b1);
        @(negedge clk);
        pin_dir[0] = 1'b0;
        pin_opt = '1;
        tick();
        chk("R2 enable while high", irq, 1'b0);

        // R3 normal falling edge
        set_pin(2, 1'b0);
        chk("R3 falling edge", irq, 1'b1);
        do_ack();
        tick();
        chk("R11 ack clears", irq, 1'b0);
        set_pin(2, 1'b1);
        chk("R3 rising ignored", irq, 1'b0);

        // R5 masking and R7 release
        set_pin(0, 1'b0);
        chk("R3 pin0 falling", irq, 1'b1);
        do_ack();
        set_pin(1, 1'b0);
        chk("R5 masked by pin0", irq, 1'b0);
        set_pin(1, 1'b1);
        set_pin(0, 1'b1);
        chk("R7 release no req", irq, 1'b0);
        set_pin(1, 1'b0);
        chk("R7 after release", irq, 1'b1);
        do_ack();
        set_pin(1, 1'b1);
        set_pin(0, 1'b0);
        do_ack();
        set_opt(0, 1'b0);
        chk("R12 plain neutral falling", irq, 1'b0);
        set_pin(3, 1'b0);
        chk("R7 after mode exit", irq, 1'b1);
        do_ack();
        set_pin(3, 1'b1);
        set_pin(0, 1'b1);
        set_opt(0, 1'b1);
        chk("R2 re-enable high", irq, 1'b0);

        // R10 edge-select to rising with pins high
        @(negedge clk);
        edge_rise = 1'b1;
        tick();
        chk("R10 select rising", irq, 1'b1);
        do_ack();

        // R4 rising edge
        @(negedge clk);
        pin_in = '0;
        tick();
        chk("R4 all low no req", irq, 1'b0);
        set_pin(2, 1'b1);
        chk("R4 rising edge", irq, 1'b1);
        do_ack();
        set_pin(2, 1'b0);
        chk("R4 falling ignored", irq, 1'b0);

        // R6 masking in rising mode
        set_pin(0, 1'b1);
        do_ack();
        set_pin(1, 1'b1);
        chk("R6 masked by pin0", irq, 1'b0);
        set_pin(1, 1'b0);
        set_pin(0, 1'b0);
        set_pin(3, 1'b1);
        chk("R7 rising after release", irq, 1'b1);
        do_ack();
        set_pin(3, 1'b0);

        // R9 interrupt to plain while low in rising mode
        set_opt(2, 1'b0);
        chk("R9 leave mode low", irq, 1'b1);
        do_ack();
        set_pin(1, 1'b1);
        chk("R12 plain low masks rising", irq, 1'b0);
        set_pin(1, 1'b0);
        set_pin(2, 1'b1);
        set_pin(1, 1'b1);
        chk("R12 plain high unmasks", irq, 1'b1);
        do_ack();

        // R8 plain to interrupt while low in falling mode
        @(negedge clk);
        pin_in = '1;
        edge_rise = 1'b0;
        tick();
        do_ack();
        set_pin(2, 1'b0);
        chk("R12 plain ignored falling", irq, 1'b0);
        set_opt(2, 1'b1);
        chk("R8 enter mode low", irq, 1'b1);

        // R11 hold and collision
        set_pin(2, 1'b1);
        repeat (3) tick();
        chk("R11 hold without ack", irq, 1'b1);
        @(negedge clk);
        pin_in[2] = 1'b0;
        irq_ack = 1'b1;
        tick();
        chk("R11 edge beats ack", irq, 1'b1);
        @(negedge clk);
        irq_ack = 1'b0;
        do_ack();
        tick();
        chk("R11 ack after collision", irq, 1'b0);

        // sweep over all pattern pairs, all pins in interrupt mode
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < (1 << N); p++) begin
                for (int q = 0; q < (1 << N); q++) begin
                    @(negedge clk);
                    pin_in = p[N-1:0];
                    edge_rise = e[0];
                    tick();
                    @(negedge clk);
                    irq_ack = 1'b1;
                    tick();
                    @(negedge clk);
                    irq_ack = 1'b0;
                    pin_in = q[N-1:0];
                    tick();
                    chk(e == 0 ? "R3/R5 sweep falling" : "R4/R6 sweep rising", irq,
                        ref_lvl(p[N-1:0], e[0]) & ~ref_lvl(q[N-1:0], e[0]));
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule